// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block sits in the command path of an SDRAM controller. It follows which of the four banks hold an open row, and which row that is. It decides, one request at a time, whether the requested command may go to the memory on the current clock edge. A request carries a command code, a bank number and a row address. The block answers with exactly one of three outcomes. **Grant** means the command is issued on this edge. **Stall** means the command is legal but a spacing rule is not yet met, so the requester holds it. **Illegal** means the command does not fit the state of its bank and is never granted.

The timing limits are parameters given in nanoseconds, together with the clock period in nanoseconds. Each limit becomes a whole number of clocks by dividing by the period and rounding up. The block keeps three kinds of down-counter:
- a per-bank row-to-column delay (tRCD) that gates reads and writes after an activate;
- a per-bank activate-to-activate cycle time (tRC) that gates the next activate to the same bank;
- a single activate-to-activate delay (tRRD) shared by all banks.

The request side follows valid/ready rules. `req_valid` qualifies the request, and `req_grant` is the ready that completes the transfer. While `req_stall` is high the requester must keep the same request stable until it is granted. A request flagged `req_illegal` is never accepted, and the requester must withdraw or replace it. Outcomes are combinational from the request and the registered state. State changes only on the edge where a grant is given.

Top module: `sdram_act_tracker`

## Requirements
- R1: Reset closes every bank, clears the open-row outputs to zero and clears every timing counter, so an activate presented on the first cycle after reset is granted.
- R2: Each limit in ns becomes ceil(limit / period) clocks. With the defaults (period 8 ns, tRCD 18 ns, tRC 64 ns, tRRD 12 ns) these are 3, 8 and 2 clocks, and tRC is an exact multiple that is not rounded.
- R3: A read/write (`req_cmd` = 2'b10) to a closed bank is flagged illegal and is never granted.
- R4: An activate (`req_cmd` = 2'b01) to a bank that is already open is flagged illegal. A precharge (`req_cmd` = 2'b11) is always granted without waiting and closes its bank from the next cycle.
- R5: A read/write to a bank is stalled until at least tRCD clocks have passed since that bank's granted activate. It is granted on the first cycle at that distance.
- R6: An activate to a bank is stalled until at least tRC clocks have passed since the previous granted activate to the same bank, even when the bank has been precharged in between.
- R7: Any two granted activates, to the same or different banks, are at least tRRD clocks apart. An activate that comes earlier is stalled.
- R8: A no-op (`req_cmd` = 2'b00) with `req_valid` high is always granted and changes no bank state.
- R9: Exactly one of grant, stall and illegal is high while `req_valid` is high. All three are low while it is low.
- R10: After a granted activate, `bank_open` shows the bank as open from the next cycle. `bank_row` slice b (bits b*ROW_W upward) holds the row that the activate carried.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | 00 no-op, 01 activate, 10 read/write, 11 precharge |
| req_bank | input | BANK_W (2) | Target bank |
| req_row | input | ROW_W (12) | Row address, used by activate |
| req_grant | output | 1 | Request accepted on this edge (ready) |
| req_stall | output | 1 | Legal request held back by a timing rule |
| req_illegal | output | 1 | Request does not fit bank state; never granted |
| bank_open | output | NUM_BANKS (4) | One bit per bank, high when a row is open |
| bank_row | output | NUM_BANKS*ROW_W (48) | Open row of each bank, bank 0 in the low bits |

## Verification
The hardest case to reach is a tRC stall that is not hidden behind any other rule. The bank must already be precharged so that the activate is legal. The shared tRRD counter must already be zero. The same-bank activate must then land exactly one clock short of tRC, and again exactly at tRC. The stimulus table opens bank 0 early and spends the gap activating other banks and a precharge. This places the reactivation of bank 0 at distances 7 and 8 with tRRD already expired, and the default period makes that boundary an exact, unrounded multiple. A cycle-stamped log of every grant in the bench checks the spacings independently of the table.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RW  = 2'b10,
    CMD_PRE = 2'b11
  } cmd_e;

  // ceil(ns / period)
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  // value loaded into a down-counter so that the follow-up is allowed clks edges later
  function automatic int unsigned load_of(input int unsigned clks);
    return (clks == 0) ? 0 : clks - 1;
  endfunction

  function automatic int unsigned width_of(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/trk_countdown.sv
module trk_countdown #(
  parameter int unsigned W    = 4,
  parameter int unsigned LOAD = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= W'(LOAD);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/trk_bank.sv
module trk_bank #(
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned RCD_W  = 2,
  parameter int unsigned RCD_LD = 2,
  parameter int unsigned RC_W   = 3,
  parameter int unsigned RC_LD  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rcd_done,
  output logic             rc_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (act_fire) begin
      is_open  <= 1'b1;
      open_row <= row_in;
    end else if (pre_fire) begin
      is_open  <= 1'b0;
    end
  end

  trk_countdown #(.W(RCD_W), .LOAD(RCD_LD)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(act_fire), .zero(rcd_done)
  );

  trk_countdown #(.W(RC_W), .LOAD(RC_LD)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(act_fire), .zero(rc_done)
  );
endmodule

// File: rtl/sdram_act_tracker.sv
module sdram_act_tracker
  import sdram_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned ROW_W         = 12,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_RCD_NS      = 18,
  parameter int unsigned T_RC_NS       = 64,
  parameter int unsigned T_RRD_NS      = 12,
  localparam int unsigned BANK_W       = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_cmd,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic [ROW_W-1:0]           req_row,
  output logic                       req_grant,
  output logic                       req_stall,
  output logic                       req_illegal,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row
);
  localparam int unsigned RCD_CLK = ns_to_clk(T_RCD_NS, CLK_PERIOD_NS);
  localparam int unsigned RC_CLK  = ns_to_clk(T_RC_NS,  CLK_PERIOD_NS);
  localparam int unsigned RRD_CLK = ns_to_clk(T_RRD_NS, CLK_PERIOD_NS);
  localparam int unsigned RCD_LD  = load_of(RCD_CLK);
  localparam int unsigned RC_LD   = load_of(RC_CLK);
  localparam int unsigned RRD_LD  = load_of(RRD_CLK);
  localparam int unsigned RCD_W   = width_of(RCD_LD);
  localparam int unsigned RC_W    = width_of(RC_LD);
  localparam int unsigned RRD_W   = width_of(RRD_LD);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] sel;
  logic [NUM_BANKS-1:0] rcd_done;
  logic [NUM_BANKS-1:0] rc_done;
  logic                 rrd_done;
  logic                 legal;
  logic                 timing_ok;
  logic                 act_go;
  logic                 pre_go;

  assign cmd = cmd_e'(req_cmd);

  // legality and timing readiness of the presented command
  always_comb begin
    legal     = 1'b1;
    timing_ok = 1'b1;
    unique case (cmd)
      CMD_ACT: begin
        legal     = ~bank_open[req_bank];
        timing_ok = rc_done[req_bank] & rrd_done;
      end
      CMD_RW: begin
        legal     = bank_open[req_bank];
        timing_ok = rcd_done[req_bank];
      end
      CMD_PRE, CMD_NOP: begin
        legal     = 1'b1;
        timing_ok = 1'b1;
      end
      default: begin
        legal     = 1'b1;
        timing_ok = 1'b1;
      end
    endcase
  end

  assign req_grant   = req_valid & legal & timing_ok;
  assign req_stall   = req_valid & legal & ~timing_ok;
  assign req_illegal = req_valid & ~legal;

  assign act_go = req_grant & (cmd == CMD_ACT);
  assign pre_go = req_grant & (cmd == CMD_PRE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel[b] = (req_bank == BANK_W'(b));

    trk_bank #(
      .ROW_W(ROW_W), .RCD_W(RCD_W), .RCD_LD(RCD_LD), .RC_W(RC_W), .RC_LD(RC_LD)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fire (act_go & sel[b]),
      .pre_fire (pre_go & sel[b]),
      .row_in   (req_row),
      .is_open  (bank_open[b]),
      .open_row (bank_row[b*ROW_W +: ROW_W]),
      .rcd_done (rcd_done[b]),
      .rc_done  (rc_done[b])
    );
  end

  trk_countdown #(.W(RRD_W), .LOAD(RRD_LD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(act_go), .zero(rrd_done)
  );
endmodule

// File: rtl/sdram_act_tracker_chk.sv
module sdram_act_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned ROW_W         = 12,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_RCD_NS      = 18,
  parameter int unsigned T_RC_NS       = 64,
  parameter int unsigned T_RRD_NS      = 12,
  localparam int unsigned BANK_W       = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 req_cmd,
  input logic [BANK_W-1:0]          req_bank,
  input logic [ROW_W-1:0]           req_row,
  input logic                       req_grant,
  input logic                       req_stall,
  input logic                       req_illegal,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row
);
  localparam logic [7:0] RCD_G = 8'(ns_to_clk(T_RCD_NS, CLK_PERIOD_NS));
  localparam logic [7:0] RC_G  = 8'(ns_to_clk(T_RC_NS,  CLK_PERIOD_NS));
  localparam logic [7:0] RRD_G = 8'(ns_to_clk(T_RRD_NS, CLK_PERIOD_NS));

  logic [7:0]       since_bank [NUM_BANKS];
  logic [7:0]       since_any;
  logic [ROW_W-1:0] row_of     [NUM_BANKS];
  logic             g_act, g_rw, g_pre, v_nop;

  assign g_act = req_grant & (req_cmd == 2'b01);
  assign g_rw  = req_grant & (req_cmd == 2'b10);
  assign g_pre = req_grant & (req_cmd == 2'b11);
  assign v_nop = req_valid & (req_cmd == 2'b00);

  always_comb
    for (int b = 0; b < NUM_BANKS; b++) row_of[b] = bank_row[b*ROW_W +: ROW_W];

  // cycles since the last granted activate, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_any <= 8'hFF;
      for (int b = 0; b < NUM_BANKS; b++) since_bank[b] <= 8'hFF;
    end else begin
      since_any <= g_act ? 8'd1 : (since_any == 8'hFF ? 8'hFF : since_any + 8'd1);
      for (int b = 0; b < NUM_BANKS; b++)
        if (g_act && req_bank == BANK_W'(b)) since_bank[b] <= 8'd1;
        else if (since_bank[b] != 8'hFF)     since_bank[b] <= since_bank[b] + 8'd1;
    end
  end

  AST_RESET_CLOSED: assert property (@(posedge clk) !rst_n |=> bank_open == '0); // R1
  AST_RW_OPEN: assert property (@(posedge clk) disable iff (!rst_n) g_rw |-> bank_open[req_bank]); // R3
  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) g_act |-> !bank_open[req_bank]); // R4
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) g_pre |=> !bank_open[$past(req_bank)]); // R4
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n) g_rw |-> since_bank[req_bank] >= RCD_G); // R5
  AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n) g_act |-> since_bank[req_bank] >= RC_G); // R6
  AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n) g_act |-> since_any >= RRD_G); // R7
  AST_NOP_PASS: assert property (@(posedge clk) disable iff (!rst_n) v_nop |-> req_grant); // R8
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) v_nop |=> $stable(bank_open)); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({req_grant, req_stall, req_illegal})); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |-> !(req_grant | req_stall | req_illegal)); // R9
  AST_ACT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    g_act |=> bank_open[$past(req_bank)] && row_of[$past(req_bank)] == $past(req_row)); // R10
endmodule

bind sdram_act_tracker sdram_act_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_RCD_NS(T_RCD_NS), .T_RC_NS(T_RC_NS), .T_RRD_NS(T_RRD_NS)
) u_chk (.*);

// File: tb/tb_sdram_act_tracker.sv
module tb_sdram_act_tracker;
  localparam int CLK_NS = 10;
  localparam int PER = 8, RCD_NS = 18, RC_NS = 64, RRD_NS = 12;
  // expected clock counts, rounded up by hand: 18/8 -> 3, 64/8 -> 8, 12/8 -> 2
  localparam int RCD_C = 3, RC_C = 8, RRD_C = 2;
  localparam logic [1:0] NOP = 2'b00, ACT = 2'b01, RW = 2'b10, PRE = 2'b11;
  localparam logic [1:0] G = 2'd0, S = 2'd1, I = 2'd2;
  localparam int NV = 19;
  // {cmd, bank, row, expected outcome}
  localparam logic [17:0] VEC [NV] = '{
    {RW,  2'd0, 12'h000, I},  // R3 closed bank
    {ACT, 2'd0, 12'h123, G},  // R1 first activate
    {RW,  2'd0, 12'h000, S},  // R5 distance 1
    {ACT, 2'd1, 12'h456, G},  // R7 distance 2
    {RW,  2'd0, 12'h000, G},  // R5 distance 3
    {ACT, 2'd2, 12'h321, G},  // R7
    {ACT, 2'd3, 12'h000, S},  // R7 distance 1
    {PRE, 2'd0, 12'h000, G},  // R4
    {ACT, 2'd0, 12'h000, S},  // R6 distance 7
    {ACT, 2'd0, 12'h0AA, G},  // R6 distance 8, exact multiple
    {ACT, 2'd3, 12'h000, S},  // R7
    {ACT, 2'd3, 12'h777, G},  // R7
    {ACT, 2'd1, 12'h000, I},  // R4 open bank
    {RW,  2'd1, 12'h000, G},  // R5
    {NOP, 2'd0, 12'h000, G},  // R8
    {RW,  2'd0, 12'h000, G},  // R5
    {RW,  2'd2, 12'h000, G},  // R3
    {PRE, 2'd3, 12'h000, G},  // R4
    {RW,  2'd3, 12'h000, I}   // R3 after precharge
  };

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_cmd = 0, req_bank = 0;
  logic [11:0] req_row = 0;
  logic req_grant, req_stall, req_illegal;
  logic [3:0] bank_open;
  logic [47:0] bank_row;
  int errors = 0, checks = 0, cyc = 0;
  int last_act [4];
  int last_any;

  sdram_act_tracker #(.NUM_BANKS(4), .ROW_W(12), .CLK_PERIOD_NS(PER),
    .T_RCD_NS(RCD_NS), .T_RC_NS(RC_NS), .T_RRD_NS(RRD_NS)) dut (.*);

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int b = 0; b < 4; b++) last_act[b] = -1000;
    last_any = -1000;
  endtask

  // drive one request, sample outcome, check grant spacings against a cycle-stamped log
  task automatic step(input logic [1:0] c, input logic [1:0] b, input logic [11:0] r, output logic [1:0] got);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_bank = b; req_row = r;
    #1;
    got = req_grant ? G : req_stall ? S : req_illegal ? I : 2'd3;
    if (req_grant && c == ACT) begin
      check("R6 tRC spacing", (cyc - last_act[b]) >= RC_C, 1);
      check("R7 tRRD spacing", (cyc - last_any) >= RRD_C, 1);
      last_act[b] = cyc; last_any = cyc;
    end
    if (req_grant && c == RW) check("R5 tRCD spacing", (cyc - last_act[b]) >= RCD_C, 1);
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 0; req_cmd = NOP; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] got;
    logic [3:0] m0;
    clear_log();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check("R1 banks closed after reset", bank_open, 4'h0);
    check("R1 rows zero after reset", bank_row, 48'h0);
    check("R9 idle quiet", {req_grant, req_stall, req_illegal}, 3'b000);
    check("R2 rounding 18/8", sdram_trk_pkg::ns_to_clk(18, 8), RCD_C);
    check("R2 exact 64/8", sdram_trk_pkg::ns_to_clk(64, 8), RC_C);
    check("R2 rounding 12/8", sdram_trk_pkg::ns_to_clk(12, 8), RRD_C);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][17:16], VEC[k][15:14], VEC[k][13:2], got);
      check($sformatf("R3-table vec %0d (R5 R6 R7 R9)", k), got, VEC[k][1:0]);
    end
    idle();
    check("R10 open mask", bank_open, 4'b0111);
    check("R10 row bank0", bank_row[11:0], 12'h0AA);
    check("R10 row bank1", bank_row[23:12], 12'h456);
    check("R10 row bank2", bank_row[35:24], 12'h321);
    check("R4 bank3 closed", bank_open[3], 1'b0);

    // R8: no-op leaves state untouched
    m0 = bank_open;
    step(NOP, 2'd3, 12'hFFF, got);
    check("R8 nop granted", got, G);
    idle();
    check("R8 nop no change", bank_open, m0);

    // R1: reset mid-run clears banks and counters
    @(negedge clk); rst_n = 0; req_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1; clear_log(); #1;
    check("R1 mid-run reset closes", bank_open, 4'h0);
    step(ACT, 2'd0, 12'h055, got);
    check("R1 activate right after reset", got, G);
    step(RW, 2'd0, 12'h000, got);
    check("R5 stall at distance 1", got, S);
    step(RW, 2'd0, 12'h000, got);
    check("R5 stall at distance 2", got, S);
    step(RW, 2'd0, 12'h000, got);
    check("R5 grant at distance 3", got, G);
    step(PRE, 2'd0, 12'h000, got);
    check("R4 precharge granted", got, G);
    idle();
    check("R4 precharge closes", bank_open[0], 1'b0);
    check("R10 row kept", bank_row[11:0], 12'h055);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule